// File: doc/BRIEF.md
# Wired and Doorbell Interrupt Funnel

This block merges 64 interrupt sources into one interrupt line for a parent controller. The low 21 source numbers (0 to 20) come from wired inputs. A wired input can be a level or a pulse. It passes through a two-stage synchronizer, and only its rising edge latches a pending bit. The upper 43 source numbers (21 to 63) have no pins. A bus master raises one of them by writing its source number to a doorbell register. This lets a peripheral emulate a message-signalled interrupt with a single posted write.

Pending bits live in a 64-bit cause space that is split into two 32-bit words. A 64-bit mask space uses the same split. Source n sits in word n/32 at bit n%32, and both cause words read as one vector with word 1 as the upper half. A mask bit of 1 blocks its source. The single output is registered and is high whenever some pending bit has a clear mask bit. Software reads the cause words and handles the lowest-numbered pending source first. It then clears that bit by writing a 1 to it, and repeats until both words read zero.

Top module: `irq_funnel`

## Requirements
- R1: Out of reset both mask words (offsets 0x20 and 0x24) read 0xFFFFFFFF, both cause words (offsets 0x00 and 0x04) read zero, and `irq_out` is low.
- R2: Source n is reported in cause word n/32 at bit n%32. Word 0 is at offset 0x00 and holds sources 0 to 31. Word 1 is at offset 0x04 and holds sources 32 to 63.
- R3: Mask word 0 (offset 0x20, sources 0 to 31) and mask word 1 (offset 0x24, sources 32 to 63) are fully writable and read back what was written. A 1 in a mask bit keeps its source off `irq_out`, and a 0 lets it through.
- R4: A write to offset 0x30 whose data value v satisfies 21 <= v <= 63 sets cause bit v and changes no other bit.
- R5: A write to offset 0x30 with a data value below 21 or of 64 or more changes no cause bit.
- R6: A rising edge on `wired_irq[i]` sets cause bit i three clock edges after the input changes (two synchronizer stages plus one edge-detect stage). A wired input that stays high does not set its bit again after that bit has been cleared.
- R7: Writing a word to a cause offset clears each cause bit whose written bit is 1 and leaves the bits written 0 unchanged.
- R8: When a set (wired edge or doorbell) and a write-1 clear hit the same cause bit in the same cycle, the bit ends up set.
- R9: `irq_out` is a register. One clock edge after any cause bit is set with its mask bit clear, it reads 1. One clock edge after no such bit remains, it reads 0.
- R10: A read of any offset other than 0x00, 0x04, 0x20 or 0x24 returns zero. This includes the write-only doorbell at 0x30.
- R11: `req_ready` is always 1, so every request is accepted in the cycle its `req_valid` is high. A read returns `rsp_valid` with its data on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wired_irq | input | 21 | Asynchronous wired interrupt inputs, sources 0 to 20 |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 1 | Combined registered interrupt to the parent controller |

## Verification
Doorbell writes target the first message source (21), the first source of the upper word (32) and the last source (63). Together these separate the word split from an off-by-one in the bit index. Doorbell values just below and above the legal range, and far outside it, show whether the range check is in place. Wired inputs are driven as a single edge, as a held level that is cleared while still high, and as two simultaneous edges at both ends of the wired range. These patterns catch a level-sensitive input and a wrong synchronizer depth. Alternating mask patterns, a masked pending bit and a clear that coincides with a wired edge isolate mask polarity, the cycle count of the output register and the set-over-clear priority.

// File: rtl/irq_funnel_pkg.sv
package irq_funnel_pkg;

  // Byte offset of word idx in a bank of consecutive words starting at base.
  function automatic int unsigned word_offset(input int unsigned base,
                                              input int unsigned idx,
                                              input int unsigned stride);
    return base + idx * stride;
  endfunction

  // Doorbell values are legal inside [lo, hi).
  function automatic logic doorbell_legal(input logic [31:0] value,
                                          input int unsigned lo,
                                          input int unsigned hi);
    return (value >= 32'(lo)) && (value < 32'(hi));
  endfunction

  // Rising edge from a synchronized level and its delayed copy.
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned NUM_IN = 21,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] async_in,
  output logic [NUM_IN-1:0] rise
);
  import irq_funnel_pkg::*;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_in[i]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign rise[i] = rise_of(chain_q[STAGES-1], prev_q);
  end

endmodule

// File: rtl/irq_regif.sv
module irq_regif #(
  parameter int unsigned NUM_SRC    = 64,
  parameter int unsigned NUM_WIRED  = 21,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CAUSE_BASE = 'h00,
  parameter int unsigned MASK_BASE  = 'h20,
  parameter int unsigned DB_OFF     = 'h30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [NUM_SRC-1:0] cause_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] db_set_vec,
  output logic               db_attempt,
  output logic               rd_accept,
  output logic               rd_unmapped,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);
  import irq_funnel_pkg::*;

  localparam int unsigned WORDS  = NUM_SRC / DATA_W;
  localparam int unsigned STRIDE = DATA_W / 8;
  localparam int unsigned IDX_W  = $clog2(NUM_SRC);

  logic              wr_accept;
  logic              db_ok;
  logic [WORDS-1:0]  hit_cause;
  logic [WORDS-1:0]  hit_mask;
  logic [DATA_W-1:0] rd_word;

  assign wr_accept = req_valid & req_write;
  assign rd_accept = req_valid & ~req_write;

  for (genvar w = 0; w < WORDS; w++) begin : g_dec
    assign hit_cause[w] = (req_addr == ADDR_W'(word_offset(CAUSE_BASE, w, STRIDE)));
    assign hit_mask[w]  = (req_addr == ADDR_W'(word_offset(MASK_BASE, w, STRIDE)));
    assign clr_vec[w*DATA_W +: DATA_W] = (wr_accept && hit_cause[w]) ? req_wdata : '0;
  end

  assign db_attempt = wr_accept && (req_addr == ADDR_W'(DB_OFF));
  assign db_ok      = db_attempt && doorbell_legal(req_wdata, NUM_WIRED, NUM_SRC);
  assign db_set_vec = db_ok ? (NUM_SRC'(1) << req_wdata[IDX_W-1:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (wr_accept && hit_mask[w]) mask_q[w*DATA_W +: DATA_W] <= req_wdata;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (hit_cause[w]) rd_word = cause_q[w*DATA_W +: DATA_W];
      if (hit_mask[w])  rd_word = mask_q[w*DATA_W +: DATA_W];
    end
  end

  assign rd_unmapped = rd_accept && !((|hit_cause) || (|hit_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_accept;
      if (rd_accept) rsp_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned NUM_WIRED = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIRED-1:0] wired_rise,
  input  logic [NUM_SRC-1:0]   db_set_vec,
  input  logic [NUM_SRC-1:0]   clr_vec,
  input  logic [NUM_SRC-1:0]   mask_q,
  output logic [NUM_SRC-1:0]   set_vec,
  output logic [NUM_SRC-1:0]   cause_q,
  output logic                 irq_out
);

  assign set_vec = db_set_vec | NUM_SRC'(wired_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      irq_out <= 1'b0;
    end else begin
      cause_q <= (cause_q & ~clr_vec) | set_vec;
      irq_out <= |(cause_q & ~mask_q);
    end
  end

endmodule

// File: rtl/irq_funnel.sv
module irq_funnel #(
  parameter int unsigned NUM_SRC     = 64,
  parameter int unsigned NUM_WIRED   = 21,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIRED-1:0] wired_irq,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 irq_out
);

  logic [NUM_WIRED-1:0] wired_rise;
  logic [NUM_SRC-1:0]   cause_q;
  logic [NUM_SRC-1:0]   mask_q;
  logic [NUM_SRC-1:0]   clr_vec;
  logic [NUM_SRC-1:0]   db_set_vec;
  logic [NUM_SRC-1:0]   set_vec;
  logic                 db_attempt;
  logic                 rd_accept;
  logic                 rd_unmapped;

  assign req_ready = 1'b1;

  irq_edge_sync #(.NUM_IN(NUM_WIRED), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (wired_irq),
    .rise     (wired_rise)
  );

  irq_regif #(
    .NUM_SRC   (NUM_SRC),
    .NUM_WIRED (NUM_WIRED),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_regif (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .cause_q     (cause_q),
    .mask_q      (mask_q),
    .clr_vec     (clr_vec),
    .db_set_vec  (db_set_vec),
    .db_attempt  (db_attempt),
    .rd_accept   (rd_accept),
    .rd_unmapped (rd_unmapped),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  irq_cause_bank #(.NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wired_rise (wired_rise),
    .db_set_vec (db_set_vec),
    .clr_vec    (clr_vec),
    .mask_q     (mask_q),
    .set_vec    (set_vec),
    .cause_q    (cause_q),
    .irq_out    (irq_out)
  );

endmodule

// File: rtl/irq_funnel_chk.sv
module irq_funnel_chk #(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned NUM_WIRED = 21,
  parameter int unsigned DATA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] cause_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] set_vec,
  input logic [NUM_SRC-1:0] clr_vec,
  input logic [NUM_SRC-1:0] db_set_vec,
  input logic               db_attempt,
  input logic [DATA_W-1:0]  db_data,
  input logic               rd_accept,
  input logic               rd_unmapped,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_rdata
);

  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(cause_q & ~mask_q))); // R9

  AST_DB_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(db_set_vec)); // R4

  AST_DB_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (db_attempt && ((db_data < DATA_W'(NUM_WIRED)) || (db_data >= DATA_W'(NUM_SRC))))
      |-> (db_set_vec == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec))); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((cause_q & $past(clr_vec & ~set_vec)) == '0)); // R7

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> rsp_valid); // R11

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (rsp_rdata == '0)); // R10

endmodule

bind irq_funnel irq_funnel_chk #(
  .NUM_SRC   (NUM_SRC),
  .NUM_WIRED (NUM_WIRED),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_out     (irq_out),
  .cause_q     (cause_q),
  .mask_q      (mask_q),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .db_set_vec  (db_set_vec),
  .db_attempt  (db_attempt),
  .db_data     (req_wdata),
  .rd_accept   (rd_accept),
  .rd_unmapped (rd_unmapped),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata)
);

// File: tb/irq_funnel_tb.sv
module irq_funnel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] wired_irq = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq_out;

  always #2 clk = ~clk;

  irq_funnel u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wired_irq (wired_irq),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq_out   (irq_out)
  );

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t    sb_q[$];
  int          n_checks = 0;
  int          n_fails  = 0;
  logic [63:0] exp_cause = '0;
  logic [63:0] exp_mask  = '1;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Register offset of the word that holds a given source (own restatement of R2/R3).
  function automatic logic [7:0] cause_off(input int src);
    return (src >= 32) ? 8'h04 : 8'h00;
  endfunction

  // Scoreboard monitor: pops one expected read per response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R11 unexpected response", 64'(rsp_rdata), 64'(0));
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(rsp_rdata === it.exp, it.tag, 64'(rsp_rdata), 64'(it.exp));
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    it.addr = a; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, "R11 rsp_valid one cycle after read", 64'(rsp_valid), 64'(1));
  endtask

  task automatic ring(input logic [31:0] v);
    reg_write(8'h30, v);
    if (v >= 21 && v < 64) exp_cause[v[5:0]] = 1'b1;
  endtask

  task automatic w1c(input logic [7:0] a, input logic [31:0] v);
    reg_write(a, v);
    if (a == 8'h00) exp_cause[31:0]  = exp_cause[31:0]  & ~v;
    else            exp_cause[63:32] = exp_cause[63:32] & ~v;
  endtask

  task automatic set_masks(input logic [31:0] lo, input logic [31:0] hi);
    reg_write(8'h20, lo);
    reg_write(8'h24, hi);
    exp_mask = {hi, lo};
  endtask

  task automatic verify_cause(input string tag);
    reg_read(8'h00, exp_cause[31:0], tag);
    reg_read(8'h04, exp_cause[63:32], tag);
  endtask

  task automatic check_irq(input logic exp, input string tag);
    check(irq_out === exp, tag, 64'(irq_out), 64'(exp));
  endtask

  task automatic clear_all();
    w1c(8'h00, 32'hFFFF_FFFF);
    w1c(8'h04, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'(0), 64'(1));
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_irq(1'b0, "R1 irq_out low after reset");
    check(req_ready === 1'b1, "R11 req_ready high", 64'(req_ready), 64'(1));
    reg_read(8'h20, 32'hFFFF_FFFF, "R1 mask word 0 reset");
    reg_read(8'h24, 32'hFFFF_FFFF, "R1 mask word 1 reset");
    verify_cause("R1 cause words reset to zero");

    // R3: mask words read back
    set_masks(32'hA5A5_5A5A, 32'h0F0F_F0F0);
    reg_read(8'h20, 32'hA5A5_5A5A, "R3 mask word 0 readback");
    reg_read(8'h24, 32'h0F0F_F0F0, "R3 mask word 1 readback");
    set_masks(32'h0, 32'h0);

    // R4/R9: first doorbell, output register latency
    ring(32'd21);
    check_irq(1'b0, "R9 irq_out not yet high in set cycle");
    @(negedge clk);
    check_irq(1'b1, "R9 irq_out high one edge after set");
    ring(32'd63);
    ring(32'd32);
    verify_cause("R2 R4 doorbell bits 21/32/63 in word split");

    // R5: illegal doorbell values
    ring(32'd20);
    ring(32'd64);
    ring(32'd0);
    ring(32'd100);
    ring(32'hFFFF_FFF5);
    verify_cause("R5 illegal doorbell values ignored");

    // R7: write-1-to-clear
    w1c(8'h04, 32'h0000_0001);
    verify_cause("R7 clear source 32 only");
    w1c(8'h00, 32'h0000_0000);
    verify_cause("R7 writing zeros clears nothing");
    clear_all();
    verify_cause("R7 all cleared");
    @(negedge clk);
    check_irq(1'b0, "R9 irq_out low once causes clear");

    // R3/R9: masked cause does not drive output
    set_masks(32'h0, 32'h0000_0100);
    ring(32'd40);
    repeat (2) @(negedge clk);
    check_irq(1'b0, "R3 masked source 40 keeps irq_out low");
    reg_read(cause_off(40), 32'h0000_0100, "R3 masked source still pending");
    reg_write(8'h24, 32'h0);
    exp_mask = '0;
    check_irq(1'b0, "R9 irq_out low in unmask cycle");
    @(negedge clk);
    check_irq(1'b1, "R3 unmask raises irq_out");
    clear_all();
    @(negedge clk);

    // R6: wired edge timing
    @(negedge clk);
    wired_irq[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check_irq(1'b0, "R6 irq_out low before cause+1 edge");
    @(negedge clk);
    check_irq(1'b1, "R6 wired edge reaches irq_out on fourth edge");
    exp_cause[5] = 1'b1;
    verify_cause("R6 wired source 5 latched");
    w1c(8'h00, 32'h0000_0020);
    repeat (4) @(negedge clk);
    verify_cause("R6 held level does not re-set after clear");
    check_irq(1'b0, "R6 irq_out low with held wired input cleared");
    wired_irq[5] = 1'b0;
    repeat (3) @(negedge clk);

    // R6: both ends of the wired range together
    wired_irq[0]  = 1'b1;
    wired_irq[20] = 1'b1;
    repeat (4) @(negedge clk);
    exp_cause[0]  = 1'b1;
    exp_cause[20] = 1'b1;
    verify_cause("R6 wired sources 0 and 20");
    wired_irq[0]  = 1'b0;
    wired_irq[20] = 1'b0;
    clear_all();
    repeat (3) @(negedge clk);

    // R8: wired edge and clear in the same cycle
    @(negedge clk);
    wired_irq[7] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    w1c(8'h00, 32'h0000_0080);
    exp_cause[7] = 1'b1;
    verify_cause("R8 set wins over same-cycle clear");
    wired_irq[7] = 1'b0;
    clear_all();

    // R10: unmapped and write-only offsets
    reg_read(8'h30, 32'h0, "R10 doorbell reads zero");
    reg_read(8'h10, 32'h0, "R10 offset 0x10 reads zero");
    reg_read(8'h28, 32'h0, "R10 offset 0x28 reads zero");
    reg_read(8'hFC, 32'h0, "R10 offset 0xFC reads zero");

    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R11 all reads answered", 64'(sb_q.size()), 64'(0));
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule